// File: doc/BRIEF.md
# Converter Reset and Power-Down Sequencer

This block decides when the digital side of a converter is held in reset, when it is initializing, when it runs and when it is powered down. It takes three inputs: a power-good level, an active-low reset pin driven from outside the chip, and an indication that the system clock is running. All of its timing is counted in system-clock cycles.

The block drives three outputs. The first is an internal active-low reset for the rest of the digital logic. The second is a clock enable for that logic. The third is a gate that forces the serial data output low whenever the data is not valid.

The reset pin has two meanings, and the length of the low period decides which one applies. A short low pulse restarts initialization when the pin rises. A low period of `LONG_HOLD` cycles (65,536 by default) puts the block into power-down, where the clock enable is removed.

Leaving power-down takes two steps. The clock must be running again, and then the pin is released, which starts a normal initialization.

Losing power-good at any moment clears the block asynchronously. It then returns to waiting for the clock.

Top module: `pwr_rst_seq`

## Requirements
- R1: While `pwr_good` is low, the outputs take these values at once, with no clock edge needed: `state_o` = 0, `core_rst_n` = 0, `core_clk_en` = 0 and `data_gate` = 1. After `pwr_good` rises, the block stays in state 0 for as long as `clk_active` is low.
- R2: In state 0, a high `clk_active` moves the block to the initialization state (1) on the next clock edge.
- R3: The initialization state lasts exactly `INIT_CYCLES` clock cycles (1024 by default), provided the pin stays high. `data_gate` is 1 for that whole time. The block then enters the run state (2) with `data_gate` = 0.
- R4: Outputs by state:
  - `core_rst_n` is 1 only in states 1 and 2.
  - `core_clk_en` is 1 in states 1, 2 and 3.
  - `data_gate` is 0 only in state 2.
- R5: The pin passes through a two-flop synchronizer. A low pulse that covers at least two rising clock edges moves the block to the held state (3), from either state 1 or state 2. When the synchronized pin returns high, a fresh and complete initialization starts, including when the pulse arrived partway through an initialization.
- R6: When the synchronized pin has been low for `LONG_HOLD` consecutive cycles, the block enters power-down (state 4), with `core_clk_en` = 0 and `data_gate` = 1. A shorter low period does not cause power-down.
- R7: The low-duration count saturates at `LONG_HOLD` and clears whenever the synchronized pin is high. Two low periods that are each shorter than `LONG_HOLD`, separated by a high period, therefore do not cause power-down.
- R8: Power-down ends only when the synchronized pin is high and `clk_active` is high together. The block then enters state 1 and runs a full initialization. A released pin with `clk_active` low leaves the block in state 4.
- R9: `state_o` encodes the states as follows: 0 wait-for-clock, 1 initialization, 2 run, 3 reset held, 4 power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Supplies valid. Low clears the block asynchronously |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| clk_active | input | 1 | System clock detected as running |
| core_rst_n | output | 1 | Internal reset for the digital core, active low |
| core_clk_en | output | 1 | Clock enable for the digital core |
| data_gate | output | 1 | 1 forces the serial data output low |
| state_o | output | 3 | Current state, encoded as in R9 |

## Verification
A wrong state shows at the ports on the same cycle, because every output is decoded from the state register, including the status code. An initialization counter that is off by one moves the fall of `data_gate` by one cycle, and counting the cycles spent in state 1 exposes that directly. A hold counter that does not clear, or that saturates wrongly, is only visible tens of thousands of cycles later, as a power-down that should not occur or that fails to occur. The bench therefore times its low holds on both sides of the threshold.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_CLK  = 3'd0,
    ST_INIT      = 3'd1,
    ST_RUN       = 3'd2,
    ST_RST_HELD  = 3'd3,
    ST_POWERDOWN = 3'd4
  } seq_state_e;
endpackage

// File: rtl/seq_sync2.sv
module seq_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/seq_hold_timer.sv
module seq_hold_timer #(
  parameter int LONG_HOLD = 65536,
  localparam int CW = $clog2(LONG_HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_low,
  output logic hold_done
);
  localparam logic [CW-1:0] LIMIT = CW'(LONG_HOLD);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!pin_low) begin
      cnt_d = '0;
    end else if (cnt_q != LIMIT) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hold_done = (cnt_q == LIMIT);

  // R7: once at the limit, a continued low keeps the count there
  p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_low && hold_done) |=> hold_done);
  // R7: a high pin empties the count
  p_clear_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_low |=> (cnt_q == '0));
endmodule

// File: rtl/seq_init_timer.sv
module seq_init_timer #(
  parameter int INIT_CYCLES = 1024,
  localparam int CW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);
  localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = '0;
    if (active && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = active && (cnt_q == LAST);

  // R3: the count only advances while initialization is active
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt_q == '0));
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
  import pwr_seq_pkg::*;
#(
  parameter int INIT_CYCLES = 1024,
  parameter int LONG_HOLD   = 65536
) (
  input  logic       clk,
  input  logic       pwr_good,
  input  logic       ext_rst_n,
  input  logic       clk_active,
  output logic       core_rst_n,
  output logic       core_clk_en,
  output logic       data_gate,
  output logic [2:0] state_o
);
  logic       arst_n;
  logic       pin_s;
  logic       init_done;
  logic       hold_done;
  seq_state_e state_q;
  seq_state_e state_d;

  // power-good: asserted asynchronously, released on the clock
  seq_sync2 #(.RST_VAL(1'b0)) u_pg_sync (
    .clk    (clk),
    .arst_n (pwr_good),
    .d      (1'b1),
    .q      (arst_n)
  );

  seq_sync2 #(.RST_VAL(1'b1)) u_pin_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d      (ext_rst_n),
    .q      (pin_s)
  );

  seq_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init_timer (
    .clk    (clk),
    .rst_n  (arst_n),
    .active (state_q == ST_INIT),
    .done   (init_done)
  );

  seq_hold_timer #(.LONG_HOLD(LONG_HOLD)) u_hold_timer (
    .clk       (clk),
    .rst_n     (arst_n),
    .pin_low   (!pin_s),
    .hold_done (hold_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_CLK:  if (clk_active) state_d = ST_INIT;
      ST_INIT: begin
        if (!pin_s)         state_d = ST_RST_HELD;
        else if (init_done) state_d = ST_RUN;
      end
      ST_RUN:       if (!pin_s) state_d = ST_RST_HELD;
      ST_RST_HELD: begin
        if (pin_s)          state_d = ST_INIT;
        else if (hold_done) state_d = ST_POWERDOWN;
      end
      ST_POWERDOWN: if (pin_s && clk_active) state_d = ST_INIT;
      default:      state_d = ST_WAIT_CLK;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state_q <= ST_WAIT_CLK;
    else         state_q <= state_d;
  end

  always_comb begin
    core_rst_n  = (state_q == ST_INIT) || (state_q == ST_RUN);
    core_clk_en = (state_q == ST_INIT) || (state_q == ST_RUN) ||
                  (state_q == ST_RST_HELD);
    data_gate   = (state_q != ST_RUN);
  end

  assign state_o = state_q;

  // R1: without a running clock the block never leaves the wait state
  p_wait_clk_r1: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_WAIT_CLK && !clk_active) |=> (state_q == ST_WAIT_CLK));
  // R3: the end of the initialization count with the pin high leads to run
  p_init_to_run_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_INIT && init_done && pin_s) |=> (state_q == ST_RUN));
  // R5: a released pin in the held state starts initialization
  p_release_init_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_RST_HELD && pin_s) |=> (state_q == ST_INIT));
  // R6: power-down is not entered before the hold timer expires
  p_no_early_pd_r6: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_RST_HELD && !hold_done) |=> (state_q != ST_POWERDOWN));
  // R8: power-down persists while the clock is reported absent
  p_pd_needs_clk_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_POWERDOWN && !clk_active) |=> (state_q == ST_POWERDOWN));
  // R4: the data gate stays closed unless the core is out of reset
  p_gate_vs_reset_r4: assert property (@(posedge clk) disable iff (!arst_n)
    !core_rst_n |-> data_gate);
endmodule

// File: tb/pwr_rst_seq_bench.sv
module pwr_rst_seq_bench;
  logic       clk;
  logic       pwr_good;
  logic       ext_rst_n;
  logic       clk_active;
  logic       core_rst_n;
  logic       core_clk_en;
  logic       data_gate;
  logic [2:0] state_o;

  int checks;
  int errors;
  bit finished;

  localparam int INIT_N = 1024;
  localparam int HOLD_N = 65536;

  pwr_rst_seq u_pwr_rst_seq (
    .clk         (clk),
    .pwr_good    (pwr_good),
    .ext_rst_n   (ext_rst_n),
    .clk_active  (clk_active),
    .core_rst_n  (core_rst_n),
    .core_clk_en (core_clk_en),
    .data_gate   (data_gate),
    .state_o     (state_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag, input int st, input int rn,
                          input int en, input int gt);
    chk({tag, " state"}, state_o, st);
    chk({tag, " core_rst_n"}, core_rst_n, rn);
    chk({tag, " clk_en"}, core_clk_en, en);
    chk({tag, " gate"}, data_gate, gt);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(input int st, input int limit);
    for (int i = 0; i < limit; i++) begin
      if (state_o == st) break;
      @(negedge clk);
    end
  endtask

  // counts consecutive cycles in initialization, noting any open gate
  task automatic count_init(output int n, output int gate_open);
    n = 0;
    gate_open = 0;
    while (state_o == 3'd1 && n < INIT_N + 10) begin
      n++;
      if (!data_gate) gate_open = 1;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    pwr_good = 1'b0; ext_rst_n = 1'b1; clk_active = 1'b0;
    cyc(3);
    chk_outs("R1 pg low", 0, 0, 0, 1);
    pwr_good = 1'b1;
    cyc(20);
    chk_outs("R1 no clk R9", 0, 0, 0, 1);
  endtask

  task automatic t_start;
    int n, g;
    clk_active = 1'b1;
    cyc(1);
    chk("R2 enters init", state_o, 1);
    chk_outs("R4 init", 1, 1, 1, 1);
    count_init(n, g);
    chk("R3 init length", n, INIT_N);
    chk("R3 gate during init", g, 0);
    chk_outs("R3 run", 2, 1, 1, 0);
  endtask

  task automatic t_short_pulse;
    int n, g;
    ext_rst_n = 1'b0;
    cyc(5);
    chk_outs("R5 held", 3, 0, 1, 1);
    ext_rst_n = 1'b1;
    wait_state(1, 10);
    chk("R5 restart init", state_o, 1);
    count_init(n, g);
    chk("R5 R3 full init", n, INIT_N);
    chk("R3 run again", state_o, 2);
  endtask

  task automatic t_mid_init;
    int n, g;
    ext_rst_n = 1'b0;
    cyc(4);
    ext_rst_n = 1'b1;
    wait_state(1, 10);
    cyc(500);
    chk("R5 mid init", state_o, 1);
    ext_rst_n = 1'b0;
    cyc(5);
    chk("R5 held from init", state_o, 3);
    ext_rst_n = 1'b1;
    wait_state(1, 10);
    count_init(n, g);
    chk("R5 fresh init length", n, INIT_N);
    chk("R5 run", state_o, 2);
  endtask

  task automatic t_split_hold;
    int n, g;
    ext_rst_n = 1'b0;
    cyc(35000);
    ext_rst_n = 1'b1;
    cyc(6);
    ext_rst_n = 1'b0;
    cyc(35000);
    chk_outs("R7 no powerdown", 3, 0, 1, 1);
    ext_rst_n = 1'b1;
    wait_state(1, 10);
    count_init(n, g);
    chk("R7 recover run", state_o, 2);
  endtask

  task automatic t_powerdown;
    int n, g;
    ext_rst_n = 1'b0;
    cyc(HOLD_N - 36);
    chk("R6 before limit", state_o, 3);
    cyc(45);
    chk_outs("R6 powerdown", 4, 0, 0, 1);
    clk_active = 1'b0;
    cyc(3);
    ext_rst_n = 1'b1;
    cyc(10);
    chk_outs("R8 wait clk in pd", 4, 0, 0, 1);
    clk_active = 1'b1;
    cyc(1);
    chk("R8 exit to init", state_o, 1);
    count_init(n, g);
    chk("R8 full init", n, INIT_N);
    chk("R8 run", state_o, 2);
  endtask

  task automatic t_pg_drop;
    #1 pwr_good = 1'b0;
    #1;
    chk_outs("R1 async drop", 0, 0, 0, 1);
    @(negedge clk);
    pwr_good = 1'b1;
    clk_active = 1'b1;
    wait_state(1, 10);
    chk("R1 R2 restart", state_o, 1);
  endtask

  initial begin
    checks = 0; errors = 0; finished = 0;
    pwr_good = 1'b0; ext_rst_n = 1'b1; clk_active = 1'b0;
    @(negedge clk);
    t_reset();
    t_start();
    t_short_pulse();
    t_mid_init();
    t_split_hold();
    t_powerdown();
    t_pg_drop();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (185000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule